// File: doc/BRIEF.md
# Multi-Mode Control Pin Sequencer

This block turns one shared, active-low external control pin into one of three chip-level actions. A 2-bit mode field picks the action. In reset mode the pin clears both register banks to their default values at once, with no clock needed. When the pin goes high again, the block issues one alignment pulse. In power-down mode the pin puts the chip to sleep and leaves all programmed settings as they are. In sync mode the pin only holds the output dividers in alignment.

All timing runs on the fast clock. The raw pin passes through a two-flop synchronizer before any level or edge is used. The one exception is the reset assertion path, which acts on the raw pin directly. Its release is synchronized.

The sync hold is active in every mode. Whenever the synchronized pin is low, `sync_no` is low, whatever the mode field says. The chip power-on reset `rst_ni` works like a pin reset: it asserts `reset_defaults_o` while low and produces the same release pulse when it goes high.

Top module: `ctrl_pin_seq`

## Requirements
- R1: With mode field 00 (reset) and the pin low, `reset_defaults_o` goes high at once, with no clock edge needed.
- R2: In reset mode, after the pin returns high, `reset_defaults_o` stays high through the first rising clock edge and drops after the second.
- R3: After `reset_defaults_o` drops, `sync_no` goes low for exactly one cycle, starting at the next rising clock edge.
- R4: In every mode, `sync_no` is low from the second rising edge after the pin falls until the second rising edge after the pin rises.
- R5: With mode field 11 (power-down), `powerdown_o` is high exactly while the synchronized pin is low. Following the same two-edge latency as R4, `reset_defaults_o` stays low, and releasing the pin produces no extra `sync_no` pulse.
- R6: With mode field 01 (sync) or 10 (reserved), a low pin asserts neither `reset_defaults_o` nor `powerdown_o`.
- R7: While `rst_ni` is low, `reset_defaults_o` is high and `powerdown_o` is low. The release of `rst_ni` follows the timing of R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| pin_ni | input | 1 | Raw shared control pin, active low |
| mode_i | input | 2 | Pin function: 00 reset, 01 sync, 10 reserved, 11 power-down |
| reset_defaults_o | output | 1 | Load default values into both register banks |
| sync_no | output | 1 | Active-low divider alignment hold and start pulse |
| powerdown_o | output | 1 | Chip-wide sleep request |

## Verification
A release synchronizer stuck in reset would show at the ports as `reset_defaults_o` never dropping and no `sync_no` pulse within three edges of the release. An edge detector that is off by one shows as a pulse in the wrong cycle, or a pulse two cycles wide. A wrong mode decode shows within two edges of the pin falling: either `powerdown_o` or `reset_defaults_o` asserts in a mode where it should stay low, or the sync hold disappears in a non-sync mode. Every check samples at a fixed edge count after each pin change.

// File: rtl/ctrl_pin_pkg.sv
package ctrl_pin_pkg;
  typedef enum logic [1:0] {
    PIN_RESET = 2'b00,
    PIN_SYNC  = 2'b01,
    PIN_RSVD  = 2'b10,
    PIN_PDOWN = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_q <= '1;   // released pin level
    else         s_q <= {s_q[STAGES-2:0], d_i};
  end

  assign q_o = s_q[STAGES-1];
endmodule

// File: rtl/rst_release.sv
module rst_release #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arst_ni,
  output logic rst_active_o,
  output logic release_pulse_o
);
  logic [STAGES-1:0] r_q;
  logic              done_d_q;
  logic              pulse_q;

  // async assert, synchronized deassert
  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) r_q <= '0;
    else          r_q <= {r_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_d_q <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      done_d_q <= r_q[STAGES-1];
      pulse_q  <= r_q[STAGES-1] & ~done_d_q;
    end
  end

  assign rst_active_o    = ~r_q[STAGES-1];
  assign release_pulse_o = pulse_q;

  a_r3_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);
  a_r2_release_synced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(r_q[STAGES-1]) |-> $past(r_q[STAGES-2]));
  a_r3_pulse_after_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_q) |-> $past(rst_active_o == 1'b0) && $past(done_d_q == 1'b0));
endmodule

// File: rtl/ctrl_pin_seq.sv
module ctrl_pin_seq
  import ctrl_pin_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_ni,
  input  logic [1:0] mode_i,
  output logic       reset_defaults_o,
  output logic       sync_no,
  output logic       powerdown_o
);
  logic pin_s;
  logic mode_rst;
  logic mode_pd;
  logic arst_n;
  logic rst_active;
  logic rel_pulse;

  assign mode_rst = (pin_mode_e'(mode_i) == PIN_RESET);
  assign mode_pd  = (pin_mode_e'(mode_i) == PIN_PDOWN);

  pin_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_ni),
    .q_o    (pin_s)
  );

  // raw pin bypasses synchronizer for assertion
  assign arst_n = rst_ni & ~(mode_rst & ~pin_ni);

  rst_release #(.STAGES(SYNC_STAGES)) u_rst_release (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .arst_ni         (arst_n),
    .rst_active_o    (rst_active),
    .release_pulse_o (rel_pulse)
  );

  assign reset_defaults_o = rst_active;
  assign sync_no          = pin_s & ~rel_pulse;  // sync hold active in all modes
  assign powerdown_o      = mode_pd & ~pin_s;

  a_r1_async_defaults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_rst && !pin_ni) |-> reset_defaults_o);
  a_r4_sync_follows_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pin_s) |-> !sync_no);
  a_r5_pd_holds_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    powerdown_o |-> !sync_no);
endmodule

// File: tb/tb_ctrl_pin_seq.sv
module tb_ctrl_pin_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pin_ni = 1'b1;
  logic [1:0] mode_i = 2'b00;
  logic       reset_defaults_o, sync_no, powerdown_o;
  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  ctrl_pin_seq dut (.*);

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic t_por();
    rst_ni = 1'b0; pin_ni = 1'b1; mode_i = 2'b00;
    edges(2);
    chk(reset_defaults_o, 1'b1, "R7 defaults in por");
    chk(powerdown_o, 1'b0, "R7 no powerdown in por");
    rst_ni = 1'b1;
    edges(1); chk(reset_defaults_o, 1'b1, "R7 defaults after 1 edge");
    edges(1); chk(reset_defaults_o, 1'b0, "R7 defaults released");
    chk(sync_no, 1'b1, "R7 sync idle");
    edges(1); chk(sync_no, 1'b0, "R7 release pulse");
    edges(1); chk(sync_no, 1'b1, "R7 pulse ended");
  endtask

  task automatic t_reset_mode();
    int lows;
    mode_i = 2'b00;
    edges(2);
    pin_ni = 1'b0;
    #0.5;
    chk(reset_defaults_o, 1'b1, "R1 async defaults");
    edges(2);
    chk(sync_no, 1'b0, "R4 sync hold in reset mode");
    chk(powerdown_o, 1'b0, "R6 no pd in reset mode");
    pin_ni = 1'b1;
    edges(1); chk(reset_defaults_o, 1'b1, "R2 held after 1 edge");
    edges(1); chk(reset_defaults_o, 1'b0, "R2 released after 2 edges");
    chk(sync_no, 1'b1, "R4 hold ends");
    lows = 0;
    for (int i = 0; i < 4; i++) begin
      edges(1);
      if (i == 0) chk(sync_no, 1'b0, "R3 pulse at next edge");
      if (!sync_no) lows++;
    end
    chk(lows == 1, 1'b1, "R3 pulse one cycle wide");
  endtask

  task automatic t_pd_mode();
    mode_i = 2'b11;
    edges(1);
    pin_ni = 1'b0;
    edges(1); chk(powerdown_o, 1'b0, "R5 pd latency 1 edge");
    edges(1); chk(powerdown_o, 1'b1, "R5 pd asserted");
    chk(reset_defaults_o, 1'b0, "R5 settings kept");
    chk(sync_no, 1'b0, "R4 sync hold in pd mode");
    edges(3); chk(powerdown_o, 1'b1, "R5 pd held");
    pin_ni = 1'b1;
    edges(1); chk(powerdown_o, 1'b1, "R5 pd held 1 edge after release");
    edges(1); chk(powerdown_o, 1'b0, "R5 pd released");
    chk(sync_no, 1'b1, "R4 hold ends pd");
    for (int i = 0; i < 3; i++) begin
      edges(1);
      chk(sync_no, 1'b1, "R5 no release pulse");
      chk(reset_defaults_o, 1'b0, "R5 no defaults");
    end
  endtask

  task automatic t_other_mode(input logic [1:0] m, input string tag);
    mode_i = m;
    edges(1);
    pin_ni = 1'b0;
    #0.5;
    chk(reset_defaults_o, 1'b0, {"R6 no async defaults ", tag});
    edges(2);
    chk(sync_no, 1'b0, {"R4 sync hold ", tag});
    chk(powerdown_o, 1'b0, {"R6 no pd ", tag});
    chk(reset_defaults_o, 1'b0, {"R6 no defaults ", tag});
    pin_ni = 1'b1;
    edges(2); chk(sync_no, 1'b1, {"R4 hold released ", tag});
    edges(1); chk(sync_no, 1'b1, {"R6 no pulse ", tag});
    chk(reset_defaults_o, 1'b0, {"R6 defaults low after ", tag});
  endtask

  initial begin
    fork
      begin
        t_por();
        t_reset_mode();
        t_pd_mode();
        t_other_mode(2'b01, "sync");
        t_other_mode(2'b10, "reserved");
      end
      begin
        repeat (5000) @(posedge clk_i);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule